// File: doc/BRIEF.md
# Sub-Dword Operand Select Unit

This unit sits around a 32-bit vector lane ALU and lets an operation work on part of a 32-bit register. For each of two source operands it picks a byte, a 16-bit half or the whole word, then widens the picked part to 32 bits. The widening is zero extension by default, or sign extension when that source's extend flag is set. The two conditioned operands go to the ALU.

The ALU result comes back in and is placed into the chosen part of the destination. The destination bits outside that part are filled in one of three ways: zeros, copies of the part's sign bit, or the previous destination contents. The destination and each source have their own part-select code.

All three outputs are registered, so each result appears one clock after its inputs. The ALU itself is not part of the block.

Top module: `sdw_operand_sel`

## Requirements
- R1: A source select code picks the part as follows: 0 to 3 pick byte k at bits [8k+7:8k], 4 picks bits [15:0], 5 picks bits [31:16], and 6 or 7 pick all 32 bits.
- R2: With its extend flag clear, a source with a byte or half selected is output with the part in the low bits and all higher bits zero.
- R3: With its extend flag set, a source with a byte or half selected is output with all bits above the part equal to the part's top bit.
- R4: With select code 6 or 7, a source is output unchanged whatever its extend flag.
- R5: The destination output holds the low 8 or 16 bits of the ALU result at the bit position of the selected destination part, using the same code table as R1.
- R6: Unused mode 0 (pad), and reserved mode 3, makes every destination bit outside the part zero.
- R7: Unused mode 1 (sign) fills the destination bits above the part with the part's top bit, and makes the bits below the part zero.
- R8: Unused mode 2 (keep) takes the destination bits outside the part from the old destination input.
- R9: With destination select code 6 or 7, the destination output equals the ALU result whatever the unused mode.
- R10: Outputs are registered, and each output reflects the inputs of the previous clock. A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src0_i | input | 32 | First source operand |
| src1_i | input | 32 | Second source operand |
| dst_old_i | input | 32 | Previous destination contents |
| alu_res_i | input | 32 | ALU result to merge |
| dst_sel_i | input | 3 | Destination part-select code |
| src0_sel_i | input | 3 | First source part-select code |
| src1_sel_i | input | 3 | Second source part-select code |
| unused_mode_i | input | 2 | Fill policy for destination bits outside the part |
| src0_sext_i | input | 1 | Sign-extend flag for the first source |
| src1_sext_i | input | 1 | Sign-extend flag for the second source |
| opnd0_o | output | 32 | Conditioned first operand |
| opnd1_o | output | 32 | Conditioned second operand |
| dst_o | output | 32 | Merged destination value |

## Verification
The assertions compare each output with the inputs registered one cycle earlier. They therefore assume the inputs carry known values on every clock after reset, including the reserved select and mode codes, which must still be driven as defined values. The stimulus drives every input from time zero and changes the inputs only between clock edges. It sweeps all eight select codes for the destination and for each source, all four unused modes and both extend-flag values. The data patterns set part sign bits both high and low, so every code stays inside the defined behaviour.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int DW = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int SHW = $clog2(DW);
    localparam int LENW = SHW + 1;

    typedef enum logic [2:0] {
        SEL_B0  = 3'd0,
        SEL_B1  = 3'd1,
        SEL_B2  = 3'd2,
        SEL_B3  = 3'd3,
        SEL_H0  = 3'd4,
        SEL_H1  = 3'd5,
        SEL_ALL = 3'd6,
        SEL_RSV = 3'd7
    } part_sel_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_KEEP = 2'd2,
        FILL_RSV  = 2'd3
    } fill_mode_e;

    typedef struct packed {
        logic [SHW-1:0]  lsb;
        logic [LENW-1:0] len;
    } part_geom_t;

    function automatic part_geom_t part_geom(part_sel_e s);
        part_geom_t g;
        case (s)
            SEL_B0:  begin g.lsb = SHW'(0);          g.len = LENW'(BYTE_W); end
            SEL_B1:  begin g.lsb = SHW'(BYTE_W);     g.len = LENW'(BYTE_W); end
            SEL_B2:  begin g.lsb = SHW'(2 * BYTE_W); g.len = LENW'(BYTE_W); end
            SEL_B3:  begin g.lsb = SHW'(3 * BYTE_W); g.len = LENW'(BYTE_W); end
            SEL_H0:  begin g.lsb = SHW'(0);          g.len = LENW'(HALF_W); end
            SEL_H1:  begin g.lsb = SHW'(HALF_W);     g.len = LENW'(HALF_W); end
            default: begin g.lsb = SHW'(0);          g.len = LENW'(DW);     end
        endcase
        return g;
    endfunction

    function automatic logic [DW-1:0] len_mask(logic [LENW-1:0] len);
        logic [DW-1:0] m;
        m = '1;
        if (len < LENW'(DW)) m = (DW'(1) << len) - DW'(1);
        return m;
    endfunction

endpackage

// File: rtl/sdw_src_extract.sv
module sdw_src_extract
    import sdw_pkg::*;
(
    input  logic [DW-1:0] src_i,
    input  part_sel_e     sel_i,
    input  logic          sext_i,
    output logic [DW-1:0] val_o
);
    part_geom_t    geom;
    logic [DW-1:0] keep_m;
    logic [DW-1:0] field;
    logic          top_bit;

    always_comb begin
        geom    = part_geom(sel_i);
        keep_m  = len_mask(geom.len);
        field   = (src_i >> geom.lsb) & keep_m;
        top_bit = field[SHW'(geom.len - LENW'(1))];
        if (sext_i && (geom.len < LENW'(DW)) && top_bit)
            val_o = field | ~keep_m;
        else
            val_o = field;
    end
endmodule

// File: rtl/sdw_dst_merge.sv
module sdw_dst_merge
    import sdw_pkg::*;
(
    input  logic [DW-1:0] res_i,
    input  logic [DW-1:0] old_i,
    input  part_sel_e     sel_i,
    input  fill_mode_e    mode_i,
    output logic [DW-1:0] dst_o
);
    part_geom_t    geom;
    logic [DW-1:0] len_m;
    logic [DW-1:0] slot_m;
    logic [DW-1:0] below_m;
    logic [DW-1:0] above_m;
    logic [DW-1:0] placed;
    logic          top_bit;

    always_comb begin
        geom    = part_geom(sel_i);
        len_m   = len_mask(geom.len);
        slot_m  = len_m << geom.lsb;
        below_m = (DW'(1) << geom.lsb) - DW'(1);
        above_m = ~(slot_m | below_m);
        placed  = (res_i & len_m) << geom.lsb;
        top_bit = res_i[SHW'(geom.len - LENW'(1))];
        case (mode_i)
            FILL_KEEP: dst_o = placed | (old_i & ~slot_m);
            FILL_SIGN: dst_o = placed | (top_bit ? above_m : '0);
            default:   dst_o = placed;
        endcase
    end
endmodule

// File: rtl/sdw_operand_sel.sv
module sdw_operand_sel
    import sdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src0_i,
    input  logic [31:0] src1_i,
    input  logic [31:0] dst_old_i,
    input  logic [31:0] alu_res_i,
    input  logic [2:0]  dst_sel_i,
    input  logic [2:0]  src0_sel_i,
    input  logic [2:0]  src1_sel_i,
    input  logic [1:0]  unused_mode_i,
    input  logic        src0_sext_i,
    input  logic        src1_sext_i,
    output logic [31:0] opnd0_o,
    output logic [31:0] opnd1_o,
    output logic [31:0] dst_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][DW-1:0] src_a;
    part_sel_e [NSRC-1:0]    sel_a;
    logic [NSRC-1:0]         sx_a;
    logic [NSRC-1:0][DW-1:0] val_a;
    logic [NSRC-1:0][DW-1:0] opnd_q;
    logic [DW-1:0]           dst_d;
    logic [DW-1:0]           dst_q;

    assign src_a = {src1_i, src0_i};
    assign sel_a = {part_sel_e'(src1_sel_i), part_sel_e'(src0_sel_i)};
    assign sx_a  = {src1_sext_i, src0_sext_i};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        sdw_src_extract u_ext (
            .src_i  (src_a[i]),
            .sel_i  (sel_a[i]),
            .sext_i (sx_a[i]),
            .val_o  (val_a[i])
        );
    end

    sdw_dst_merge u_merge (
        .res_i  (alu_res_i),
        .old_i  (dst_old_i),
        .sel_i  (part_sel_e'(dst_sel_i)),
        .mode_i (fill_mode_e'(unused_mode_i)),
        .dst_o  (dst_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
            dst_q  <= '0;
        end else begin
            opnd_q <= val_a;
            dst_q  <= dst_d;
        end
    end

    assign opnd0_o = opnd_q[0];
    assign opnd1_o = opnd_q[1];
    assign dst_o   = dst_q;

    AST_SRC_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        ($past(src0_sel_i) <= 3'd3 && !$past(src0_sext_i)) |-> (opnd0_o[31:8] == 24'd0)); // R2
    AST_SRC_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        ($past(src1_sel_i) == 3'd5 && $past(src1_sext_i)) |-> (opnd1_o[31:16] == {16{$past(src1_i[31])}})); // R3
    AST_SRC_WHOLE: assert property (@(posedge clk) disable iff (rst)
        ($past(src0_sel_i) >= 3'd6) |-> (opnd0_o == $past(src0_i))); // R4
    AST_DST_PAD: assert property (@(posedge clk) disable iff (rst)
        ($past(dst_sel_i) == 3'd0 && $past(unused_mode_i) == 2'd0) |-> (dst_o[31:8] == 24'd0)); // R6
    AST_DST_KEEP: assert property (@(posedge clk) disable iff (rst)
        ($past(dst_sel_i) == 3'd3 && $past(unused_mode_i) == 2'd2) |-> (dst_o[23:0] == $past(dst_old_i[23:0]))); // R8
    AST_DST_WHOLE: assert property (@(posedge clk) disable iff (rst)
        ($past(dst_sel_i) >= 3'd6) |-> (dst_o == $past(alu_res_i))); // R9
    AST_DST_SLOT: assert property (@(posedge clk) disable iff (rst)
        ($past(dst_sel_i) == 3'd5) |-> (dst_o[31:16] == $past(alu_res_i[15:0]))); // R5
endmodule

// File: tb/sdw_operand_sel_tb.sv
module sdw_operand_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src0 = '0, src1 = '0, dold = '0, res = '0;
    logic [2:0]  dsel = '0, s0sel = '0, s1sel = '0;
    logic [1:0]  mode = '0;
    logic        sx0 = 1'b0, sx1 = 1'b0;
    logic [31:0] op0, op1, dout;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sdw_operand_sel dut_i (
        .clk(clk), .rst(rst), .src0_i(src0), .src1_i(src1), .dst_old_i(dold),
        .alu_res_i(res), .dst_sel_i(dsel), .src0_sel_i(s0sel), .src1_sel_i(s1sel),
        .unused_mode_i(mode), .src0_sext_i(sx0), .src1_sext_i(sx1),
        .opnd0_o(op0), .opnd1_o(op1), .dst_o(dout)
    );

    function automatic longint part_off(int sel);
        if (sel <= 3) return 8 * sel;
        if (sel == 5) return 16;
        return 0;
    endfunction

    function automatic longint part_len(int sel);
        if (sel <= 3) return 8;
        if (sel <= 5) return 16;
        return 32;
    endfunction

    function automatic logic [31:0] exp_src(logic [31:0] v, int sel, bit sx);
        longint off = part_off(sel);
        longint w   = part_len(sel);
        longint f   = (longint'(v) / (longint'(1) << off)) % (longint'(1) << w);
        if (w < 32 && sx && f >= (longint'(1) << (w - 1)))
            f = f + ((longint'(1) << 32) - (longint'(1) << w));
        return f[31:0];
    endfunction

    function automatic logic [31:0] exp_dst(logic [31:0] r, logic [31:0] o, int sel, int md);
        longint off  = part_off(sel);
        longint w    = part_len(sel);
        longint part = longint'(r) % (longint'(1) << w);
        longint slot = ((longint'(1) << w) - 1) * (longint'(1) << off);
        longint acc  = part * (longint'(1) << off);
        if (md == 2) acc = acc + (longint'(o) & ((longint'(1) << 32) - 1 - slot));
        if (md == 1 && part >= (longint'(1) << (w - 1)))
            acc = acc + (longint'(1) << 32) - (longint'(1) << (off + w));
        return acc[31:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h (dsel=%0d mode=%0d s0=%0d/%0b s1=%0d/%0b)",
                     tag, act, exp, dsel, mode, s0sel, sx0, s1sel, sx1);
        end
    endtask

    function automatic string src_tag(int sel, bit sx);
        if (sel >= 6) return "R4";
        return sx ? "R3/R1" : "R2/R1";
    endfunction

    function automatic string dst_tag(int sel, int md);
        if (sel >= 6) return "R9";
        if (md == 1) return "R7/R5";
        if (md == 2) return "R8/R5";
        return "R6/R5";
    endfunction

    initial begin
        logic [31:0] p0 [4] = '{32'h8081_7F80, 32'h0123_4567, 32'hFEDC_BA98, 32'h7F80_FF00};
        logic [31:0] p1 [4] = '{32'h00FF_8001, 32'hC3A5_5A3C, 32'h8000_7FFF, 32'h1357_9BDF};
        logic [31:0] pr [4] = '{32'hFFFF_8080, 32'h0000_7F7F, 32'h1234_F678, 32'hA5A5_00C3};
        logic [31:0] po [4] = '{32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0000_0000};
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears the registered outputs
        check("R10", op0, 32'h0);
        check("R10", op1, 32'h0);
        check("R10", dout, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        for (int d = 0; d < 8; d++)
            for (int m = 0; m < 4; m++)
                for (int s = 0; s < 8; s++)
                    for (int x = 0; x < 4; x++)
                        for (int p = 0; p < 4; p++) begin
                            @(negedge clk);
                            dsel  = 3'(d);
                            mode  = 2'(m);
                            s0sel = 3'(s);
                            s1sel = 3'((s + 3) % 8);
                            sx0   = x[0];
                            sx1   = x[1];
                            src0  = p0[p];
                            src1  = p1[(p + x) % 4];
                            res   = pr[(p + s) % 4];
                            dold  = po[(p + m) % 4];
                            @(posedge clk);
                            #1;
                            // R10: outputs follow the previous edge's inputs
                            check(src_tag(s, x[0]), op0, exp_src(src0, s, x[0]));
                            check(src_tag((s + 3) % 8, x[1]), op1, exp_src(src1, (s + 3) % 8, x[1]));
                            check(dst_tag(d, m), dout, exp_dst(res, dold, d, m));
                        end
        // R10: synchronous reset clears the outputs again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10", op0, 32'h0);
        check("R10", op1, 32'h0);
        check("R10", dout, 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule